// File: doc/BRIEF.md
# Pointer-Register Address Generator

This block turns a 16-bit pointer, held as two adjacent 8-bit registers, into the address for an indirect data-memory load or store. It also computes the new pointer value for the register file when the addressing mode needs one. There are four modes. Plain and displacement modes leave the pointer unchanged. Pre-decrement steps the pointer back before the access. Post-increment steps it forward after the access. The pointer write-back is issued in the same cycle as the memory strobe.

The same block serves byte reads from program memory. These always use the fixed register pair at index 30/31 as the pointer. That pair is stepped forward only when post-increment is requested. Any other mode reads through it unchanged. The register file sits outside the block: it reads the pair selected by `ptr_base` and returns its two bytes. A load returns its byte one cycle later on a destination write port. A store drives the source register byte onto the write-data bus.

Top module: `ptr_addr_gen`

## Requirements
- R1: The pointer is `{ptr_hi, ptr_lo}`: the register at the selected index gives bits 7:0 and the register one index above gives bits 15:8. The write-back value is split the same way onto `ptr_whi`/`ptr_wlo`.
- R2: Mode 0 (plain): `mem_addr` equals the pointer and `ptr_we` stays low.
- R3: Mode 1 (pre-decrement): `mem_addr` equals pointer minus 1. `ptr_we` is high and writes back that same decremented value.
- R4: Mode 2 (post-increment): `mem_addr` equals the unmodified pointer. `ptr_we` is high and writes back pointer plus 1.
- R5: Mode 3 (displacement): `mem_addr` equals pointer plus the zero-extended 6-bit `disp` (0 to 63), and `ptr_we` stays low.
- R6: All address and write-back arithmetic wraps modulo 2^16. For example, 0x0000 pre-decremented gives 0xFFFF, and 0xFFFF plus 1 gives 0x0000.
- R7: Operation code 3 (program read): `ptr_base` is 30, `pgm_rd` is high and `pgm_addr` equals the pointer. `ptr_we` is high, with pointer plus 1, only in mode 2. Modes 0, 1 and 3 leave the pointer unchanged and ignore `disp`.
- R8: Operation codes are 1 = load and 2 = store. For these, `ptr_base` follows `ptr_sel`. A load raises only `mem_rd`. A store raises only `mem_wr` and drives `src_byte` onto `mem_wdata`.
- R9: One cycle after `mem_rd` or `pgm_rd`, `dst_we` is high and `dst_wdata` carries `mem_rdata` or `pgm_rdata` respectively. In any other cycle after reset, `dst_we` is low.
- R10: Operation code 0 (idle) raises no memory strobe and no pointer write-back, whatever the mode.
- R11: While reset is held and in the first cycle after it, `dst_we` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 2 | 0 idle, 1 load, 2 store, 3 program read |
| mode | input | 2 | 0 plain, 1 pre-decrement, 2 post-increment, 3 displacement |
| disp | input | 6 | Unsigned displacement |
| ptr_sel | input | 5 | Low register index of the pair for data accesses |
| ptr_base | output | 5 | Low register index of the pair being used |
| ptr_lo | input | 8 | Register at `ptr_base` |
| ptr_hi | input | 8 | Register at `ptr_base`+1 |
| src_byte | input | 8 | Source register byte for stores |
| mem_addr | output | 16 | Data-memory effective address |
| mem_rd | output | 1 | Data-memory read strobe |
| mem_wr | output | 1 | Data-memory write strobe |
| mem_wdata | output | 8 | Data-memory write data |
| mem_rdata | input | 8 | Data-memory read data, one cycle after `mem_rd` |
| pgm_addr | output | 16 | Program-memory byte address |
| pgm_rd | output | 1 | Program-memory read strobe |
| pgm_rdata | input | 8 | Program-memory read data, one cycle after `pgm_rd` |
| ptr_we | output | 1 | Pointer pair write-back enable |
| ptr_wlo | output | 8 | Write-back low byte |
| ptr_whi | output | 8 | Write-back high byte |
| dst_we | output | 1 | Destination register write enable |
| dst_wdata | output | 8 | Destination register write data |

## Verification
The assertions take `op` and `mode` to be known, two-bit values in every cycle after reset. They also take the register file to present the pair named by `ptr_base` in the same cycle. The bench meets both conditions: it drives every input from time zero and changes the inputs only on the falling clock edge. It also returns fixed pointer bytes directly, so `ptr_lo`/`ptr_hi` never depend on a stale `ptr_base`.

// File: rtl/ptr_addr_gen.sv
module ptr_addr_gen #(
  parameter int DW    = 8,
  parameter int DISPW = 6,
  parameter int RIDXW = 5,
  parameter int ZBASE = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       op,
  input  logic [1:0]       mode,
  input  logic [DISPW-1:0] disp,
  input  logic [RIDXW-1:0] ptr_sel,
  output logic [RIDXW-1:0] ptr_base,
  input  logic [DW-1:0]    ptr_lo,
  input  logic [DW-1:0]    ptr_hi,
  input  logic [DW-1:0]    src_byte,
  output logic [2*DW-1:0]  mem_addr,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  output logic [2*DW-1:0]  pgm_addr,
  output logic             pgm_rd,
  input  logic [DW-1:0]    pgm_rdata,
  output logic             ptr_we,
  output logic [DW-1:0]    ptr_wlo,
  output logic [DW-1:0]    ptr_whi,
  output logic             dst_we,
  output logic [DW-1:0]    dst_wdata
);

  localparam int PW = 2 * DW;
  localparam logic [RIDXW-1:0] ZIDX = RIDXW'(ZBASE);
  localparam logic [1:0] OP_LOAD = 2'd1, OP_STORE = 2'd2, OP_PGM = 2'd3;
  localparam logic [1:0] M_PLAIN = 2'd0, M_PREDEC = 2'd1, M_POSTINC = 2'd2, M_DISP = 2'd3;
  localparam logic [PW-1:0] ONE = PW'(1);

  logic [PW-1:0] ptr, ptr_inc, ptr_dec, eff, wb_val;
  logic          data_op, wb_req, rd_q, pgm_q;

  assign ptr     = {ptr_hi, ptr_lo};
  assign ptr_inc = ptr + ONE;
  assign ptr_dec = ptr - ONE;
  assign data_op = (op == OP_LOAD) || (op == OP_STORE);

  always_comb begin
    eff    = ptr;
    wb_val = ptr;
    wb_req = 1'b0;
    case (mode)
      M_PLAIN:   ;
      M_PREDEC:  begin eff = ptr_dec; wb_val = ptr_dec; wb_req = 1'b1; end
      M_POSTINC: begin wb_val = ptr_inc; wb_req = 1'b1; end
      M_DISP:    eff = ptr + {{(PW-DISPW){1'b0}}, disp};
      default:   ;
    endcase
  end

  assign ptr_base  = (op == OP_PGM) ? ZIDX : ptr_sel;
  assign mem_addr  = eff;
  assign mem_rd    = (op == OP_LOAD);
  assign mem_wr    = (op == OP_STORE);
  assign mem_wdata = src_byte;
  assign pgm_addr  = ptr;
  assign pgm_rd    = (op == OP_PGM);

  assign ptr_we             = data_op ? wb_req : (pgm_rd && mode == M_POSTINC);
  assign {ptr_whi, ptr_wlo} = data_op ? wb_val : ptr_inc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q  <= 1'b0;
      pgm_q <= 1'b0;
    end else begin
      rd_q  <= mem_rd || pgm_rd;
      pgm_q <= pgm_rd;
    end
  end

  assign dst_we    = rd_q;
  assign dst_wdata = pgm_q ? pgm_rdata : mem_rdata;

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, mem_wr, pgm_rd}));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd || mem_wr || pgm_rd) |-> !ptr_we);

  // R3
  predec_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_we && (mem_rd || mem_wr) && mode == M_PREDEC) |-> ({ptr_whi, ptr_wlo} == mem_addr));

  // R4
  postinc_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_we && (mem_rd || mem_wr) && mode == M_POSTINC) |-> ({ptr_whi, ptr_wlo} == mem_addr + ONE));

  // R7
  pgm_zpair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_rd |-> (ptr_base == ZIDX));

  // R7
  pgm_wb_only_postinc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_rd && ptr_we) |-> (mode == M_POSTINC && {ptr_whi, ptr_wlo} == pgm_addr + ONE));

  // R9
  load_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || pgm_rd) |=> dst_we);

  // R9
  no_spurious_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd || pgm_rd) |=> !dst_we);

endmodule

// File: tb/test_ptr_addr_gen.sv
module test_ptr_addr_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] op = 2'd0, mode = 2'd0;
  logic [5:0] disp = 6'd0;
  logic [4:0] ptr_sel = 5'd26;
  logic [4:0] ptr_base;
  logic [7:0] ptr_lo = 8'h00, ptr_hi = 8'h00, src_byte = 8'h00;
  logic [7:0] mem_rdata = 8'h00, pgm_rdata = 8'h00;
  logic [15:0] mem_addr, pgm_addr;
  logic mem_rd, mem_wr, pgm_rd, ptr_we, dst_we;
  logic [7:0] mem_wdata, ptr_wlo, ptr_whi, dst_wdata;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  ptr_addr_gen i_ptr_addr_gen (
    .clk(clk), .rst_n(rst_n), .op(op), .mode(mode), .disp(disp),
    .ptr_sel(ptr_sel), .ptr_base(ptr_base), .ptr_lo(ptr_lo), .ptr_hi(ptr_hi),
    .src_byte(src_byte), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .pgm_addr(pgm_addr),
    .pgm_rd(pgm_rd), .pgm_rdata(pgm_rdata), .ptr_we(ptr_we), .ptr_wlo(ptr_wlo),
    .ptr_whi(ptr_whi), .dst_we(dst_we), .dst_wdata(dst_wdata)
  );

  // {op, mode, disp, pointer, expected address, expected write-back enable, expected write-back}
  localparam int NV = 12;
  localparam logic [58:0] VEC [NV] = '{
    {2'd1, 2'd0, 6'd0,  16'h1234, 16'h1234, 1'b0, 16'h0000},
    {2'd2, 2'd1, 6'd0,  16'h1234, 16'h1233, 1'b1, 16'h1233},
    {2'd1, 2'd2, 6'd0,  16'h00FF, 16'h00FF, 1'b1, 16'h0100},
    {2'd2, 2'd3, 6'h3F, 16'h1000, 16'h103F, 1'b0, 16'h0000},
    {2'd1, 2'd1, 6'd0,  16'h0000, 16'hFFFF, 1'b1, 16'hFFFF},
    {2'd2, 2'd2, 6'd0,  16'hFFFF, 16'hFFFF, 1'b1, 16'h0000},
    {2'd1, 2'd3, 6'h01, 16'hFFFF, 16'h0000, 1'b0, 16'h0000},
    {2'd3, 2'd2, 6'd0,  16'h0200, 16'h0200, 1'b1, 16'h0201},
    {2'd3, 2'd0, 6'd0,  16'h0300, 16'h0300, 1'b0, 16'h0000},
    {2'd3, 2'd1, 6'd0,  16'h0300, 16'h0300, 1'b0, 16'h0000},
    {2'd3, 2'd3, 6'h05, 16'h0300, 16'h0300, 1'b0, 16'h0000},
    {2'd0, 2'd2, 6'd0,  16'h1234, 16'h0000, 1'b0, 16'h0000}
  };

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] o, input logic [1:0] m, input logic [5:0] d, input logic [15:0] p);
    @(negedge clk);
    op = o; mode = m; disp = d; {ptr_hi, ptr_lo} = p;
    #1;
  endtask

  initial begin
    #100000;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    src_byte = 8'h5A;
    repeat (3) @(negedge clk);
    // R11
    check(dst_we == 1'b0, "R11 dst_we during reset", 32'(dst_we), 0);
    op = 2'd1;
    @(negedge clk);
    rst_n = 1'b1;
    op = 2'd0;
    #1;
    check(dst_we == 1'b0, "R11 dst_we after reset", 32'(dst_we), 0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] vo, vm; logic [5:0] vd; logic [15:0] vp, va, vw; logic ve;
      {vo, vm, vd, vp, va, ve, vw} = VEC[i];
      drive(vo, vm, vd, vp);
      if (vo == 2'd1 || vo == 2'd2) begin
        check(mem_addr == va, "R1 R2 R3 R4 R5 R6 mem_addr", 32'(mem_addr), 32'(va));
        check(ptr_base == ptr_sel, "R8 ptr_base", 32'(ptr_base), 32'(ptr_sel));
      end else if (vo == 2'd3) begin
        check(pgm_addr == va, "R7 pgm_addr", 32'(pgm_addr), 32'(va));
        check(ptr_base == 5'd30, "R7 ptr_base", 32'(ptr_base), 30);
      end
      check({mem_rd, mem_wr, pgm_rd} == {vo == 2'd1, vo == 2'd2, vo == 2'd3},
            "R8 R10 strobes", 32'({mem_rd, mem_wr, pgm_rd}), 32'({vo == 2'd1, vo == 2'd2, vo == 2'd3}));
      check(ptr_we == ve, "R2 R3 R4 R5 R7 R10 ptr_we", 32'(ptr_we), 32'(ve));
      if (ve)
        check({ptr_whi, ptr_wlo} == vw, "R1 R3 R4 R6 R7 write-back", 32'({ptr_whi, ptr_wlo}), 32'(vw));
    end

    // R8 store data
    drive(2'd2, 2'd0, 6'd0, 16'h0042);
    check(mem_wdata == 8'h5A, "R8 mem_wdata", 32'(mem_wdata), 32'h5A);

    // R9 load return from data memory
    mem_rdata = 8'hA5; pgm_rdata = 8'h3C;
    drive(2'd1, 2'd0, 6'd0, 16'h0042);
    drive(2'd0, 2'd0, 6'd0, 16'h0042);
    check(dst_we == 1'b1, "R9 dst_we after load", 32'(dst_we), 1);
    check(dst_wdata == 8'hA5, "R9 dst_wdata load", 32'(dst_wdata), 32'hA5);

    // R9 program read return
    drive(2'd3, 2'd2, 6'd0, 16'h0042);
    drive(2'd0, 2'd0, 6'd0, 16'h0042);
    check(dst_we == 1'b1, "R9 dst_we after pgm read", 32'(dst_we), 1);
    check(dst_wdata == 8'h3C, "R9 dst_wdata pgm", 32'(dst_wdata), 32'h3C);

    // R9 store gives no return
    drive(2'd2, 2'd1, 6'd0, 16'h0042);
    drive(2'd0, 2'd0, 6'd0, 16'h0042);
    check(dst_we == 1'b0, "R9 dst_we after store", 32'(dst_we), 0);

    // R5 R6 large displacement crossing the top
    drive(2'd1, 2'd3, 6'h3F, 16'hFFF0);
    check(mem_addr == 16'h002F, "R5 R6 disp wrap", 32'(mem_addr), 32'h2F);

    // R10 idle in every mode
    for (int m = 0; m < 4; m++) begin
      drive(2'd0, 2'(m), 6'h11, 16'h8000);
      check(!mem_rd && !mem_wr && !pgm_rd && !ptr_we, "R10 idle quiet",
            32'({mem_rd, mem_wr, pgm_rd, ptr_we}), 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule